// File: doc/BRIEF.md
# Numerically Controlled Oscillator Phase Path

This block produces the phase sequence of a direct digital synthesizer. Every clock it adds one of two 28-bit tuning words to a 28-bit phase accumulator, which wraps modulo 2^28. One of two 12-bit phase offsets is added to the top 12 bits of the accumulator, and the 12-bit sum leaves the block as the address for an external sine table. The same phase MSB also drives a square-wave output. That output is either the MSB itself or the MSB divided by two.

Four control functions can come either from control bits or from external pins: tuning-word select, offset select, clear and hold. A source-select input decides which set is used. Clear forces the accumulator to zero, which is the midscale point of the waveform. Hold freezes accumulation so that the phase output stays where it is. The phase output is a continuous sample stream with no back-pressure: the consumer reads it every cycle, so the interface has no valid/ready pair.

Top module: `nco_phase_core`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, the accumulator is zero, `phase_addr` equals the selected phase offset, and `sqr_out` is 0.
- R2: On each clock edge where clear and hold are both inactive, the accumulator gains the selected tuning word. `phase_addr` is combinational: it is accumulator bits [27:16] plus the selected offset, modulo 2^12.
- R3: The accumulator wraps modulo 2^28, so a tuning word of 0xFFFFFFF steps the phase backwards by one.
- R4: Select value 0 picks `freq_word0` and select value 1 picks `freq_word1`. A change takes effect on the next clock edge.
- R5: Select value 0 picks `phase_ofs0` and select value 1 picks `phase_ofs1`. The offset add wraps modulo 2^12.
- R6: While clear is 1, the accumulator is zero from the next edge on and stays there. Clear takes priority over hold.
- R7: While hold is 1 and clear is 0, the accumulator does not change, so `phase_addr` stays stable.
- R8: With `pin_mode`=1, the tuning-word select, offset select, clear and hold come from the `pin_*` inputs and the `ctl_*` inputs are ignored. With `pin_mode`=0 the reverse holds.
- R9: With `sqr_en`=1 and `sqr_full`=1, `sqr_out` equals `phase_addr[11]`.
- R10: With `sqr_en`=1 and `sqr_full`=0, `sqr_out` is a divider flag. The flag toggles at each clock edge where `phase_addr[11]` is 1 and was 0 at the previous non-held edge. With `sqr_en`=0, `sqr_out` is 0.
- R11: Clear resets the divider flag and its MSB history to 0. Hold freezes both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word0 | input | 28 | Tuning word, select 0 |
| freq_word1 | input | 28 | Tuning word, select 1 |
| phase_ofs0 | input | 12 | Phase offset, select 0 |
| phase_ofs1 | input | 12 | Phase offset, select 1 |
| pin_mode | input | 1 | 1: control from pins, 0: from control bits |
| ctl_fsel | input | 1 | Tuning-word select, control bit |
| ctl_psel | input | 1 | Offset select, control bit |
| ctl_clear | input | 1 | Clear, control bit |
| ctl_hold | input | 1 | Hold, control bit |
| pin_fsel | input | 1 | Tuning-word select, pin |
| pin_psel | input | 1 | Offset select, pin |
| pin_clear | input | 1 | Clear, pin |
| pin_hold | input | 1 | Hold, pin |
| sqr_en | input | 1 | Square output enable |
| sqr_full | input | 1 | 1: MSB direct, 0: MSB divided by two |
| phase_addr | output | 12 | Phase address for the sine table |
| sqr_out | output | 1 | Square-wave output |

## Verification
A corrupted accumulator shows up on `phase_addr` in the first cycle after the faulty edge, and the error persists because every later value builds on it. A wrong select or source choice shows up as a wrong increment after one edge, or at once for the offset path. A wrong divider state cannot be seen while `sqr_full` is 1. It becomes visible within one MSB period once the divided mode is selected, so the bench runs long sweeps in that mode.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef struct packed {
    logic fsel;
    logic psel;
    logic clear;
    logic hold;
  } nco_ctrl_t;
endpackage

// File: rtl/nco_ctrl_mux.sv
module nco_ctrl_mux
  import nco_pkg::*;
(
  input  logic      pin_mode,
  input  nco_ctrl_t ctl_bits,
  input  nco_ctrl_t ctl_pins,
  output nco_ctrl_t ctl_eff
);
  // R8: one source set drives all four functions
  always_comb ctl_eff = pin_mode ? ctl_pins : ctl_bits;
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int ACC_W  = 28,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              hold,
  input  logic [ACC_W-1:0]  inc,
  input  logic [ADDR_W-1:0] ofs,
  output logic [ADDR_W-1:0] addr
);
  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else if (!hold) acc <= acc + inc;
  end

  always_comb addr = acc[ACC_W-1 -: ADDR_W] + ofs;

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0));
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clear) |=> $stable(acc));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !clear) |=> (acc == $past(acc) + $past(inc)));
endmodule

// File: rtl/nco_sqr_gen.sv
module nco_sqr_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic hold,
  input  logic msb,
  input  logic en,
  input  logic full,
  output logic sqr
);
  logic msb_q, div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q <= 1'b0;
      div_q <= 1'b0;
    end else if (clear) begin
      msb_q <= 1'b0;
      div_q <= 1'b0;
    end else if (!hold) begin
      msb_q <= msb;
      div_q <= div_q ^ (msb & ~msb_q);
    end
  end

  always_comb sqr = en & (full ? msb : div_q);

  p_div_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !div_q);
  p_div_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !hold && msb && !msb_q) |=> (div_q != $past(div_q)));
  p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !sqr);
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int ACC_W  = 28,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  freq_word0,
  input  logic [ACC_W-1:0]  freq_word1,
  input  logic [ADDR_W-1:0] phase_ofs0,
  input  logic [ADDR_W-1:0] phase_ofs1,
  input  logic              pin_mode,
  input  logic              ctl_fsel,
  input  logic              ctl_psel,
  input  logic              ctl_clear,
  input  logic              ctl_hold,
  input  logic              pin_fsel,
  input  logic              pin_psel,
  input  logic              pin_clear,
  input  logic              pin_hold,
  input  logic              sqr_en,
  input  logic              sqr_full,
  output logic [ADDR_W-1:0] phase_addr,
  output logic              sqr_out
);
  localparam int MSB = ADDR_W - 1;

  nco_ctrl_t bits_s, pins_s, eff_s;
  logic [ACC_W-1:0]  inc_s;
  logic [ADDR_W-1:0] ofs_s;

  always_comb begin
    bits_s = '{fsel: ctl_fsel, psel: ctl_psel, clear: ctl_clear, hold: ctl_hold};
    pins_s = '{fsel: pin_fsel, psel: pin_psel, clear: pin_clear, hold: pin_hold};
  end

  nco_ctrl_mux u_mux (
    .pin_mode (pin_mode),
    .ctl_bits (bits_s),
    .ctl_pins (pins_s),
    .ctl_eff  (eff_s)
  );

  // R4, R5: register selection
  always_comb begin
    inc_s = eff_s.fsel ? freq_word1 : freq_word0;
    ofs_s = eff_s.psel ? phase_ofs1 : phase_ofs0;
  end

  nco_accum #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (eff_s.clear),
    .hold  (eff_s.hold),
    .inc   (inc_s),
    .ofs   (ofs_s),
    .addr  (phase_addr)
  );

  nco_sqr_gen u_sqr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (eff_s.clear),
    .hold  (eff_s.hold),
    .msb   (phase_addr[MSB]),
    .en    (sqr_en),
    .full  (sqr_full),
    .sqr   (sqr_out)
  );

  p_full_msb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sqr_en && sqr_full) |-> (sqr_out == phase_addr[MSB]));
endmodule

// File: tb/nco_phase_core_tb.sv
module nco_phase_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [27:0] freq_word0 = '0, freq_word1 = '0;
  logic [11:0] phase_ofs0 = '0, phase_ofs1 = '0;
  logic pin_mode = 0, ctl_fsel = 0, ctl_psel = 0, ctl_clear = 0, ctl_hold = 0;
  logic pin_fsel = 0, pin_psel = 0, pin_clear = 0, pin_hold = 0;
  logic sqr_en = 0, sqr_full = 0;
  logic [11:0] phase_addr;
  logic sqr_out;

  int checks = 0, errors = 0;
  logic [27:0] acc_m = '0;
  logic msb_m = 0, div_m = 0;

  always #4 clk = ~clk;

  nco_phase_core u_dut (.*);

  function automatic logic e_fsel(); return pin_mode ? pin_fsel : ctl_fsel; endfunction
  function automatic logic e_psel(); return pin_mode ? pin_psel : ctl_psel; endfunction
  function automatic logic e_clr();  return pin_mode ? pin_clear : ctl_clear; endfunction
  function automatic logic e_hold(); return pin_mode ? pin_hold : ctl_hold; endfunction
  function automatic logic [11:0] exp_addr();
    return acc_m[27:16] + (e_psel() ? phase_ofs1 : phase_ofs0);
  endfunction
  function automatic logic exp_sqr();
    logic [11:0] a;
    a = exp_addr();
    return sqr_en & (sqr_full ? a[11] : div_m);
  endfunction

  task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: model updates from pre-edge state, then sample at negedge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      logic [11:0] a;
      a = exp_addr();
      if (e_clr()) begin
        acc_m = '0; msb_m = 0; div_m = 0;
      end else if (!e_hold()) begin
        div_m = div_m ^ (a[11] & ~msb_m);
        msb_m = a[11];
        acc_m = acc_m + (e_fsel() ? freq_word1 : freq_word0);
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 addr", phase_addr, 0);
    check("R1 sqr", sqr_out, 0);
  endtask

  task automatic t_accum();
    freq_word0 = 28'h0123456; phase_ofs0 = 12'h010;
    step(10);
    check("R2 addr after 10", phase_addr, exp_addr());
    step(37);
    check("R2 addr after 47", phase_addr, exp_addr());
  endtask

  task automatic t_wrap();
    ctl_clear = 1; step(1); ctl_clear = 0;
    freq_word0 = 28'hFFFFFFF; phase_ofs0 = 0;
    step(1);
    check("R3 wrap acc", {acc_m[27:16]}, 12'hFFF);
    check("R3 wrap addr", phase_addr, 12'hFFF);
    step(5);
    check("R3 backward", phase_addr, exp_addr());
  endtask

  task automatic t_fsel();
    freq_word0 = 28'h0010000; freq_word1 = 28'h0250000;
    ctl_fsel = 1; step(4);
    check("R4 freq1", phase_addr, exp_addr());
    ctl_fsel = 0; step(3);
    check("R4 freq0", phase_addr, exp_addr());
  endtask

  task automatic t_psel();
    phase_ofs0 = 12'h100; phase_ofs1 = 12'hF80;
    ctl_psel = 1; #1;
    check("R5 ofs1 wrap", phase_addr, exp_addr());
    ctl_psel = 0; #1;
    check("R5 ofs0", phase_addr, exp_addr());
    step(1);
  endtask

  task automatic t_clear();
    ctl_clear = 1; ctl_hold = 1; step(1);
    check("R6 clear", phase_addr, phase_ofs0);
    step(3);
    check("R6 held zero", phase_addr, phase_ofs0);
    ctl_clear = 0; ctl_hold = 0; step(2);
    check("R6 resume", phase_addr, exp_addr());
  endtask

  task automatic t_hold();
    logic [11:0] snap;
    step(3);
    ctl_hold = 1; step(1);
    snap = phase_addr;
    step(5);
    check("R7 hold", phase_addr, snap);
    ctl_hold = 0; step(1);
    check("R7 release", phase_addr, exp_addr());
  endtask

  task automatic t_pins();
    pin_mode = 1; ctl_hold = 1; ctl_clear = 1;
    pin_fsel = 1; step(3);
    check("R8 pins ignore ctl", phase_addr, exp_addr());
    pin_hold = 1; ctl_hold = 0; ctl_clear = 0; step(3);
    check("R8 pin hold", phase_addr, exp_addr());
    pin_clear = 1; step(1);
    check("R8 pin clear", phase_addr, exp_addr());
    pin_clear = 0; pin_hold = 0; pin_fsel = 0; pin_mode = 0; step(1);
  endtask

  task automatic t_square();
    freq_word0 = 28'h0700000; sqr_en = 1; sqr_full = 1;
    for (int i = 0; i < 20; i++) begin
      step(1);
      check("R9 msb out", sqr_out, exp_sqr());
    end
    sqr_full = 0;
    for (int i = 0; i < 300; i++) begin
      step(1);
      check("R10 div out", sqr_out, exp_sqr());
    end
    sqr_en = 0; step(1);
    check("R10 disabled", sqr_out, 0);
    sqr_en = 1;
  endtask

  task automatic t_div_clear();
    while (!div_m) step(1);
    ctl_clear = 1; step(1);
    check("R11 clear div", sqr_out, 0);
    ctl_clear = 0;
    for (int i = 0; i < 100; i++) begin
      step(1);
      if (i == 50) ctl_hold = 1;
      if (i == 60) ctl_hold = 0;
      check("R11 after clear/hold", sqr_out, exp_sqr());
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_accum();
    t_wrap();
    t_fsel();
    t_psel();
    t_clear();
    t_hold();
    t_pins();
    t_square();
    t_div_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule